// File: doc/BRIEF.md
# Microcoded Shift-and-Add Unsigned Multiplier

This block multiplies two unsigned WIDTH-bit operands over several clock cycles using a single adder. The multiplicand sits in an operand register and the multiplier in a shift register. An accumulator and a carry flag together gather each partial product. Every step shifts the carry, accumulator and multiplier right as one chain. The product bits move into the multiplier register as the multiplier bits leave it.

The sequencing has no hardwired next-state equations. It comes from a five-word control table addressed by a control address register. Each control word holds four datapath strobes, a two-bit condition selector and two next addresses. The value of the selected condition picks which next address is loaded. The flow is Moore-style: every state drives fixed strobes and tests at most one condition.

In use, the two operands are first loaded through a shared data input with two load strobes. A one-cycle start pulse then begins the multiplication. The block raises a one-cycle done pulse when the full double-width product is ready.

Top module: `shiftadd_mcode_mul`

## Requirements
- R1: After reset, `product` is all zeros, `done` is low and the controller rests at its idle address 0.
- R2: `load_b` copies `data_in` into the multiplicand register and `load_q` copies it into the multiplier register (the low half of `product`). These strobes act on any clock edge and may both be high together.
- R3: `go` is sampled only while the controller is idle. The cycle after `go` is seen, the accumulator and carry are cleared and the iteration counter is set to WIDTH-1. A `go` pulse during a multiplication has no effect on its result or timing.
- R4: In each iteration, a multiplier LSB of 1 adds the multiplicand to the accumulator in a separate add state, and the adder carry-out goes to the carry flag. An LSB of 0 skips the add state and leaves the accumulator and carry unchanged.
- R5: The shift state moves carry||accumulator||multiplier right by one bit, clears the carry and decrements the counter.
- R6: When the counter reads zero in the shift state, the controller returns to idle, so exactly WIDTH iterations run.
- R7: Control word layout: bits 11..8 are the strobes {shift_dec, clear_c, add_load, init}, bits 7..6 are the selector, bits 5..3 are next address 0 and bits 2..0 are next address 1. Selector codes: 00 always takes address 0; 01 tests `go`, 10 tests the multiplier LSB and 11 tests counter-zero, and a true test takes address 1. Addresses: idle 0, init 1, scan 2, add 3, shift 4.
- R8: When `done` is high, `product` equals the full 2*WIDTH-bit unsigned product of the loaded operands.
- R9: Counting the clock edge that samples `go` as the first, `done` rises on edge 2 + 2*WIDTH + (number of ones in the multiplier).
- R10: `done` is high for exactly one cycle. Afterwards, `product` holds its value while idle until the next start or `load_q`, and `load_b` does not disturb it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| go | input | 1 | Start request, sampled while idle |
| load_b | input | 1 | Load `data_in` into the multiplicand register |
| load_q | input | 1 | Load `data_in` into the multiplier register |
| data_in | input | WIDTH | Operand input shared by both loads |
| product | output | 2*WIDTH | Accumulator concatenated with the multiplier register |
| done | output | 1 | One-cycle pulse when the product is complete |

## Verification
The shift and hold assertions exclude cycles with `load_q` high, since an operand load overrides the shift of the multiplier register. The stimulus therefore loads operands only while the controller is idle. The start assertions take `go` as an ordinary level input. The stimulus includes single `go` pulses in the middle of a multiplication to show that they are ignored, and it drops `go` before the controller can return to idle, so no unintended second run starts.

// File: rtl/shiftadd_mcode_pkg.sv
package shiftadd_mcode_pkg;

  localparam int UADDR_W   = 3;
  localparam int UCTL_W    = 4;
  localparam int USEL_W    = 2;
  localparam int UWORD_W   = UCTL_W + USEL_W + 2 * UADDR_W;
  localparam int ROM_DEPTH = 5;

  typedef enum logic [USEL_W-1:0] {
    SEL_ALWAYS = 2'b00,
    SEL_GO     = 2'b01,
    SEL_QLSB   = 2'b10,
    SEL_ZERO   = 2'b11
  } sel_e;

  typedef enum logic [UADDR_W-1:0] {
    UA_IDLE  = 3'd0,
    UA_INIT  = 3'd1,
    UA_SCAN  = 3'd2,
    UA_ADD   = 3'd3,
    UA_SHIFT = 3'd4
  } uaddr_e;

  typedef struct packed {
    logic shift_dec;
    logic clear_c;
    logic add_load;
    logic init;
  } ctl_t;

  typedef struct packed {
    ctl_t   ctl;
    sel_e   sel;
    uaddr_e nxt0;
    uaddr_e nxt1;
  } uword_t;

  function automatic uword_t mk_word(logic [UCTL_W-1:0] strobes, sel_e sel,
                                     uaddr_e n0, uaddr_e n1);
    uword_t w;
    w.ctl  = ctl_t'(strobes);
    w.sel  = sel;
    w.nxt0 = n0;
    w.nxt1 = n1;
    return w;
  endfunction

endpackage

// File: rtl/shiftadd_mcode_rom.sv
module shiftadd_mcode_rom
  import shiftadd_mcode_pkg::*;
(
  input  uaddr_e addr,
  output uword_t word
);

  // strobes: {shift_dec, clear_c, add_load, init}
  always_comb begin
    case (addr)
      UA_IDLE:  word = mk_word(4'b0000, SEL_GO,     UA_IDLE,  UA_INIT);
      UA_INIT:  word = mk_word(4'b0101, SEL_ALWAYS, UA_SCAN,  UA_SCAN);
      UA_SCAN:  word = mk_word(4'b0000, SEL_QLSB,   UA_SHIFT, UA_ADD);
      UA_ADD:   word = mk_word(4'b0010, SEL_ALWAYS, UA_SHIFT, UA_SHIFT);
      UA_SHIFT: word = mk_word(4'b1100, SEL_ZERO,   UA_SCAN,  UA_IDLE);
      default:  word = mk_word(4'b0000, SEL_ALWAYS, UA_IDLE,  UA_IDLE);
    endcase
  end

endmodule

// File: rtl/shiftadd_mcode_seq.sv
module shiftadd_mcode_seq
  import shiftadd_mcode_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   go,
  input  logic   qlsb,
  input  logic   zero,
  input  uword_t word,
  output uaddr_e car
);

  logic   cond;
  uaddr_e car_d;

  always_comb begin
    case (word.sel)
      SEL_GO:   cond = go;
      SEL_QLSB: cond = qlsb;
      SEL_ZERO: cond = zero;
      default:  cond = 1'b0;
    endcase
    car_d = cond ? word.nxt1 : word.nxt0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) car <= UA_IDLE;
    else        car <= car_d;
  end

  p_car_legal_r7: assert property (@(posedge clk) disable iff (!rst_n)
    car <= UA_SHIFT);
  p_start_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (car == UA_IDLE && go) |=> car == UA_INIT);
  p_idle_wait_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (car == UA_IDLE && !go) |=> car == UA_IDLE);
  p_skip_add_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (car == UA_SCAN && !qlsb) |=> car == UA_SHIFT);
  p_take_add_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (car == UA_SCAN && qlsb) |=> car == UA_ADD);
  p_finish_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (car == UA_SHIFT && zero) |=> car == UA_IDLE);
  p_loop_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (car == UA_SHIFT && !zero) |=> car == UA_SCAN);

endmodule

// File: rtl/shiftadd_mcode_dp.sv
module shiftadd_mcode_dp
  import shiftadd_mcode_pkg::*;
#(
  parameter int WIDTH = 4,
  parameter int CNT_W = $clog2(WIDTH)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load_b,
  input  logic               load_q,
  input  logic [WIDTH-1:0]   data_in,
  input  ctl_t               ctl,
  output logic               qlsb,
  output logic               zero,
  output logic [2*WIDTH-1:0] product
);

  localparam logic [CNT_W-1:0] P_START = CNT_W'(WIDTH - 1);

  logic [WIDTH-1:0] b_q, q_q, a_q;
  logic             c_q;
  logic [CNT_W-1:0] p_q;

  logic [WIDTH-1:0] q_d, a_d;
  logic             c_d;
  logic [CNT_W-1:0] p_d;
  logic             a_en, c_en, q_en, p_en;
  logic [WIDTH:0]   sum;

  assign sum = {1'b0, a_q} + {1'b0, b_q};

  always_comb begin
    a_en = ctl.init | ctl.add_load | ctl.shift_dec;
    if (ctl.init)          a_d = '0;
    else if (ctl.add_load) a_d = sum[WIDTH-1:0];
    else                   a_d = {c_q, a_q[WIDTH-1:1]};

    c_en = ctl.clear_c | ctl.add_load;
    c_d  = ctl.clear_c ? 1'b0 : sum[WIDTH];

    q_en = load_q | ctl.shift_dec;
    q_d  = load_q ? data_in : {a_q[0], q_q[WIDTH-1:1]};

    p_en = ctl.init | ctl.shift_dec;
    p_d  = ctl.init ? P_START : p_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      b_q <= '0;
      q_q <= '0;
      a_q <= '0;
      c_q <= 1'b0;
      p_q <= '0;
    end else begin
      if (load_b) b_q <= data_in;
      if (q_en)   q_q <= q_d;
      if (a_en)   a_q <= a_d;
      if (c_en)   c_q <= c_d;
      if (p_en)   p_q <= p_d;
    end
  end

  assign qlsb    = q_q[0];
  assign zero    = (p_q == '0);
  assign product = {a_q, q_q};

  p_loadb_r2: assert property (@(posedge clk) disable iff (!rst_n)
    load_b |=> b_q == $past(data_in));
  p_loadq_r2: assert property (@(posedge clk) disable iff (!rst_n)
    load_q |=> q_q == $past(data_in));
  p_init_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ctl.init |=> (a_q == '0 && !c_q && p_q == P_START));
  p_add_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ctl.add_load |=> {c_q, a_q} == ({1'b0, $past(a_q)} + {1'b0, $past(b_q)}));
  p_shift_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl.shift_dec && !load_q) |=>
      (q_q == {$past(a_q[0]), $past(q_q[WIDTH-1:1])} &&
       a_q == {$past(c_q), $past(a_q[WIDTH-1:1])} &&
       !c_q && p_q == CNT_W'($past(p_q) - 1'b1)));
  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctl.init && !ctl.add_load && !ctl.shift_dec && !load_q) |=>
      ($stable(a_q) && $stable(q_q)));

endmodule

// File: rtl/shiftadd_mcode_mul.sv
module shiftadd_mcode_mul
  import shiftadd_mcode_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               go,
  input  logic               load_b,
  input  logic               load_q,
  input  logic [WIDTH-1:0]   data_in,
  output logic [2*WIDTH-1:0] product,
  output logic               done
);

  localparam int CNT_W = (WIDTH > 2) ? $clog2(WIDTH) : 1;

  logic [1:0] rst_sync;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_int_n = rst_sync[1];

  uaddr_e car;
  uword_t word;
  logic   qlsb, zero, done_d;

  shiftadd_mcode_rom u_rom (
    .addr (car),
    .word (word)
  );

  shiftadd_mcode_seq u_seq (
    .clk   (clk),
    .rst_n (rst_int_n),
    .go    (go),
    .qlsb  (qlsb),
    .zero  (zero),
    .word  (word),
    .car   (car)
  );

  shiftadd_mcode_dp #(.WIDTH(WIDTH), .CNT_W(CNT_W)) u_dp (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .load_b  (load_b),
    .load_q  (load_q),
    .data_in (data_in),
    .ctl     (word.ctl),
    .qlsb    (qlsb),
    .zero    (zero),
    .product (product)
  );

  assign done_d = (car == UA_SHIFT) && zero;

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) done <= 1'b0;
    else            done <= done_d;
  end

  p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_int_n)
    done |=> !done);
  p_done_idle_r6: assert property (@(posedge clk) disable iff (!rst_int_n)
    done |-> car == UA_IDLE);
  p_strobe_excl_r7: assert property (@(posedge clk) disable iff (!rst_int_n)
    $onehot0({word.ctl.init, word.ctl.add_load, word.ctl.shift_dec}));

endmodule

// File: tb/shiftadd_mcode_mul_bench.sv
module shiftadd_mcode_mul_bench;

  localparam int W = 4;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           go = 1'b0, load_b = 1'b0, load_q = 1'b0;
  logic [W-1:0]   data_in = '0;
  logic [2*W-1:0] product;
  logic           done;

  int n_chk = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  shiftadd_mcode_mul #(.WIDTH(W)) u_shiftadd_mcode_mul (
    .clk(clk), .rst_n(rst_n), .go(go), .load_b(load_b), .load_q(load_q),
    .data_in(data_in), .product(product), .done(done)
  );

  function automatic logic [2*W-1:0] ref_mul(logic [W-1:0] a, logic [W-1:0] b);
    return {{W{1'b0}}, a} * {{W{1'b0}}, b};
  endfunction

  function automatic int ones(logic [W-1:0] v);
    int n = 0;
    for (int i = 0; i < W; i++) n += int'(v[i]);
    return n;
  endfunction

  task automatic chk(string req, longint act, longint exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic load_ops(logic [W-1:0] b, logic [W-1:0] q);
    @(negedge clk); data_in = b; load_b = 1'b1;
    @(negedge clk); load_b = 1'b0; data_in = q; load_q = 1'b1;
    @(negedge clk); load_q = 1'b0;
  endtask

  // returns edges from go sample to done edge, and product at done
  task automatic run(bit poke, output int cyc, output logic [2*W-1:0] res);
    int cnt;
    @(negedge clk); go = 1'b1;
    @(posedge clk); cnt = 1;
    @(negedge clk); go = 1'b0;
    while (!done && cnt < 100) begin
      @(posedge clk); cnt++;
      @(negedge clk);
      go = poke && (cnt == 4);
    end
    go = 1'b0;
    cyc = cnt;
    res = product;
  endtask

  task automatic mul_check(logic [W-1:0] b, logic [W-1:0] q, bit poke, string tag);
    int cyc;
    logic [2*W-1:0] res;
    load_ops(b, q);
    run(poke, cyc, res);
    chk({tag, " R8 product"}, res, ref_mul(b, q));
    chk({tag, " R9 latency"}, cyc, 2 + 2*W + ones(q));
  endtask

  initial begin
    #(8 * 150000);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    int cyc;
    logic [2*W-1:0] res, held;
    void'($urandom(32'd20240517));

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1 product after reset", product, 0);
    chk("R1 done after reset", done, 0);

    // directed corners
    mul_check('0, '0, 1'b0, "zero*zero R6");
    mul_check('1, '1, 1'b0, "max*max R4 R5");
    mul_check('1, '0, 1'b0, "no-add path R7");
    mul_check('0, '1, 1'b0, "all-add path R7");

    // exhaustive operand space
    for (int b = 0; b < (1 << W); b++)
      for (int q = 0; q < (1 << W); q++)
        mul_check(W'(b), W'(q), 1'b0, "exhaustive");

    // random with start pulses while busy
    for (int k = 0; k < 100; k++)
      mul_check(W'($urandom), W'($urandom), 1'b1, "busy go ignored R3");

    // done pulse and hold behaviour
    load_ops(4'd13, 4'd11);
    run(1'b0, cyc, res);
    held = res;
    @(negedge clk);
    chk("R10 done one cycle", done, 0);
    repeat (3) @(negedge clk);
    chk("R10 product held idle", product, held);
    @(negedge clk); data_in = 4'd6; load_b = 1'b1;
    @(negedge clk); load_b = 1'b0;
    chk("R10 load_b leaves product", product, held);
    // Q now holds low half of the prior product
    run(1'b0, cyc, res);
    chk("R2 R8 chained multiplier", res, ref_mul(4'd6, held[W-1:0]));
    @(negedge clk); data_in = 4'd9; load_q = 1'b1;
    @(negedge clk); load_q = 1'b0;
    chk("R2 load_q low half", product[W-1:0], 9);
    chk("R2 load_q high half", product[2*W-1:W], res[2*W-1:W]);

    // simultaneous loads
    @(negedge clk); data_in = 4'd7; load_b = 1'b1; load_q = 1'b1;
    @(negedge clk); load_b = 1'b0; load_q = 1'b0;
    run(1'b0, cyc, res);
    chk("R2 both loads square", res, 49);
    chk("R9 both loads latency", cyc, 2 + 2*W + 3);

    // reset mid-operation returns to idle state
    load_ops(4'd5, 4'd3);
    @(negedge clk); go = 1'b1;
    @(negedge clk); go = 1'b0;
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 product after mid reset", product, 0);
    chk("R1 done after mid reset", done, 0);
    mul_check(4'd5, 4'd3, 1'b0, "after reset R1");

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule